// File: doc/BRIEF.md
# Configurable External Interrupt Sense Unit

This unit watches one external interrupt pin and turns its activity into an interrupt request. The pin first passes through a synchroniser clocked by the system clock. A two-bit sense field then selects one of four triggers: low level, any change, falling edge or rising edge. In the three edge modes a detected event sets a sticky flag. The interrupt acknowledge strobe or a write-one-to-clear strobe clears that flag. In level mode the flag output follows the synchronised pin directly, so the request stays up for as long as the pin is low.

The request goes to the CPU only when both the global interrupt flag and the unit's own enable are set. The sensed value is the level actually present on the pad. When the chip drives the pin itself, through a small loopback select, the driven value triggers the unit exactly as an external signal would. This gives software a way to raise the interrupt.

Edge detection compares the sense-qualified value of the current sample with the value stored on the previous cycle. A change of the sense field while the enable is set can therefore create a spurious event. A change made while the enable is clear cannot.

Top module: `ext_irq_sense`

## Requirements
- R1: After synchronous reset, irq_flag and irq_req are 0. The synchroniser stages hold 1, which represents an idle high pin, and the stored trigger history is 0.
- R2: A pin change is seen through a two-stage synchroniser. In level mode irq_flag changes after the second rising clock edge. In edge modes the flag sets on the third rising edge.
- R3: Sense code 2'b00 (low level): irq_flag is 1 exactly while the synchronised pin is 0, and no latched flag is used.
- R4: In level mode the acknowledge and write-one-to-clear strobes do not lower irq_flag while the pin stays low.
- R5: Sense code 2'b01 sets the flag on every change of the synchronised pin, in either direction.
- R6: Sense code 2'b10 sets the flag on a high-to-low transition only.
- R7: Sense code 2'b11 sets the flag on a low-to-high transition only. A falling transition leaves the flag at 0.
- R8: In edge modes the flag is sticky. It is cleared by flag_ack or flag_w1c. When an event and a clear arrive in the same cycle, the event wins.
- R9: irq_req equals irq_flag AND irq_en AND gie.
- R10: In edge modes an event sets the flag only while irq_en is 1. Pin activity with irq_en at 0 leaves the flag at 0.
- R11: The trigger history is updated every cycle with the value qualified by the current sense code. Switching the code from 2'b10 to 2'b11 with irq_en set while the pin is high sets the flag on the next edge. The same switch made with irq_en clear, followed by at least one cycle before enabling, sets nothing.
- R12: When drv_en is 1 the sensed pin is drv_val and pin_raw is ignored, so a value the chip drives can trigger the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external pin level |
| drv_en | input | 1 | Pad driven by the chip (loopback select) |
| drv_val | input | 1 | Value driven onto the pad |
| irq_en | input | 1 | Unit interrupt enable |
| gie | input | 1 | Global interrupt enable |
| sense | input | 2 | Trigger select: 00 low, 01 any, 10 fall, 11 rise |
| flag_ack | input | 1 | Clear strobe from interrupt acknowledge |
| flag_w1c | input | 1 | Write-one-to-clear strobe for the flag |
| irq_flag | output | 1 | Interrupt flag (live pin state in level mode) |
| irq_req | output | 1 | Request to the CPU |

## Verification
The low-level pattern holds the pin low across an acknowledge. This separates a live level request from a latched one.

Single falling and rising transitions are applied in each edge mode. They show that each mode reacts only to its own direction, and the any-change mode must react to both.

Clears that coincide with events show which of the two takes priority. Activity with the enable cleared, and requests with gie or the enable low, separate flag gating from request gating.

The sense field is switched from falling to rising on a high pin twice, once with the enable set and once with it cleared. Only the first switch may raise a spurious flag. Finally, the pad is driven from the loopback value while the raw pin stays still.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_t;

    typedef struct packed {
        logic now;
        logic prev;
    } trig_hist_t;

    function automatic logic qualify(input sense_t s, input logic lvl);
        case (s)
            SNS_LOW, SNS_FALL: qualify = ~lvl;
            default:           qualify = lvl;
        endcase
    endfunction

    function automatic logic is_level(input sense_t s);
        is_level = (s == SNS_LOW);
    endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
                p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> chain[i] == $past(chain[i-1]));
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eis_detect.sv
module eis_detect
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lvl,
    input  sense_t sense,
    output logic   event_o
);
    trig_hist_t h;

    assign h.now = qualify(sense, lvl);

    always_ff @(posedge clk) begin
        if (rst) h.prev <= 1'b0;
        else     h.prev <= h.now;
    end

    always_comb begin
        if (sense == SNS_ANY) event_o = h.now ^ h.prev;
        else                  event_o = h.now & ~h.prev;
    end

    // R11: history tracks qualified value every cycle
    p_hist_track_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> h.prev == $past(qualify(sense, lvl)));
endmodule

// File: rtl/eis_flag.sv
module eis_flag
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_t sense,
    input  logic   lvl,
    input  logic   event_i,
    input  logic   en,
    input  logic   clr,
    output logic   flag
);
    logic flag_q;
    logic set_c;
    logic lvl_mode;

    assign lvl_mode = is_level(sense);
    assign set_c    = event_i & en & ~lvl_mode;

    always_ff @(posedge clk) begin
        if (rst || lvl_mode) flag_q <= 1'b0;
        else if (set_c)      flag_q <= 1'b1;
        else if (clr)        flag_q <= 1'b0;
    end

    assign flag = lvl_mode ? ~lvl : flag_q;

    p_event_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (event_i && en && !lvl_mode) |=> flag_q);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !event_i) |=> !flag_q);
    p_no_set_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !en) |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic       drv_en,
    input  logic       drv_val,
    input  logic       irq_en,
    input  logic       gie,
    input  logic [1:0] sense,
    input  logic       flag_ack,
    input  logic       flag_w1c,
    output logic       irq_flag,
    output logic       irq_req
);
    localparam logic PIN_IDLE = 1'b1;

    logic   pad;
    logic   lvl;
    logic   evt;
    sense_t mode;

    assign mode = sense_t'(sense);
    assign pad  = drv_en ? drv_val : pin_raw;

    eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(pad), .q(lvl)
    );

    eis_detect u_det (
        .clk(clk), .rst(rst), .lvl(lvl), .sense(mode), .event_o(evt)
    );

    eis_flag u_flag (
        .clk(clk), .rst(rst), .sense(mode), .lvl(lvl), .event_i(evt),
        .en(irq_en), .clr(flag_ack | flag_w1c), .flag(irq_flag)
    );

    assign irq_req = irq_flag & irq_en & gie;

    p_req_gated_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (gie && irq_en));
    p_level_live_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == SNS_LOW) |-> (irq_flag == !lvl));
    p_level_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == SNS_LOW && $past(mode) == SNS_LOW && !lvl && flag_ack) |=>
        (mode != SNS_LOW || lvl || irq_flag));
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_raw = 1'b1, drv_en = 1'b0, drv_val = 1'b0;
    logic irq_en = 1'b0, gie = 1'b0, flag_ack = 1'b0, flag_w1c = 1'b0;
    logic [1:0] sense = 2'b00;
    logic irq_flag, irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_sense u0 (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .drv_en(drv_en), .drv_val(drv_val),
        .irq_en(irq_en), .gie(gie), .sense(sense), .flag_ack(flag_ack),
        .flag_w1c(flag_w1c), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // behavioural reference model
    bit q_sync[$] = '{1'b1, 1'b1};
    bit m_prev = 1'b0;
    bit m_flag = 1'b0;

    function automatic bit m_qual(input logic [1:0] s, input bit v);
        return (s == 2'b00 || s == 2'b10) ? !v : v;
    endfunction

    function automatic bit m_flag_out();
        return (sense == 2'b00) ? !q_sync[1] : m_flag;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            q_sync = '{1'b1, 1'b1};
            m_prev = 1'b0;
            m_flag = 1'b0;
        end else begin
            bit cur, ev;
            cur = m_qual(sense, q_sync[1]);
            ev  = (sense == 2'b01) ? (cur != m_prev) : (cur && !m_prev);
            if (sense == 2'b00)                m_flag = 1'b0;
            else if (ev && irq_en)             m_flag = 1'b1;
            else if (flag_ack || flag_w1c)     m_flag = 1'b0;
            m_prev = cur;
            void'(q_sync.pop_back());
            q_sync.push_front(drv_en ? drv_val : pin_raw);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ef, er;
            ef = m_flag_out();
            er = ef && irq_en && gie;
            checks++;
            if (irq_flag !== ef || irq_req !== er) begin
                errors++;
                $display("FAIL %s model: flag=%b req=%b expected flag=%b req=%b",
                         cur_req, irq_flag, irq_req, ef, er);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drv();
        @(negedge clk); #1;
    endtask

    task automatic clear_flag();
        drv(); flag_w1c = 1'b1;
        drv(); flag_w1c = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        drv(); irq_en = 1'b0; sense = m;
        cyc(2);
        #1 irq_en = 1'b1;
        clear_flag();
    endtask

    initial begin : watchdog
        wait (cycles > 5000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3); #1 rst = 1'b0;
        @(negedge clk);
        chk(irq_flag, 1'b0, "R1 reset flag");
        chk(irq_req, 1'b0, "R1 reset req");

        // R3 low level, R2 latency
        cur_req = "R3";
        #1 irq_en = 1'b1; gie = 1'b1; sense = 2'b00; pin_raw = 1'b0;
        @(negedge clk); chk(irq_flag, 1'b0, "R2 level after one edge");
        @(negedge clk); chk(irq_flag, 1'b1, "R2 level after two edges");
        chk(irq_req, 1'b1, "R3 level request");
        // R4 ack ignored in level mode
        cur_req = "R4";
        #1 flag_ack = 1'b1; flag_w1c = 1'b1;
        drv(); flag_ack = 1'b0; flag_w1c = 1'b0;
        cyc(1); chk(irq_flag, 1'b1, "R4 level survives ack");
        #1 pin_raw = 1'b1; cyc(2);
        chk(irq_flag, 1'b0, "R3 pin high drops flag");

        // R6 falling
        cur_req = "R6";
        set_mode(2'b10);
        #1 pin_raw = 1'b0;
        cyc(2); chk(irq_flag, 1'b0, "R2 edge after two edges");
        cyc(1); chk(irq_flag, 1'b1, "R6 falling sets");
        cur_req = "R8";
        #1 pin_raw = 1'b1; cyc(4);
        chk(irq_flag, 1'b1, "R8 sticky after pin returns");
        #1 flag_ack = 1'b1;
        drv(); flag_ack = 1'b0;
        chk(irq_flag, 1'b0, "R8 ack clears");

        // R7 rising
        cur_req = "R7";
        set_mode(2'b11);
        #1 pin_raw = 1'b0; cyc(4);
        chk(irq_flag, 1'b0, "R7 falling ignored");
        #1 pin_raw = 1'b1; cyc(3);
        chk(irq_flag, 1'b1, "R7 rising sets");
        clear_flag();
        chk(irq_flag, 1'b0, "R8 w1c clears");

        // R5 any change
        cur_req = "R5";
        set_mode(2'b01);
        #1 pin_raw = 1'b0; cyc(3);
        chk(irq_flag, 1'b1, "R5 fall sets");
        clear_flag();
        #1 pin_raw = 1'b1; cyc(3);
        chk(irq_flag, 1'b1, "R5 rise sets");
        clear_flag();

        // R8 set wins over simultaneous clear
        cur_req = "R8";
        #1 pin_raw = 1'b0; flag_ack = 1'b1; cyc(3);
        chk(irq_flag, 1'b1, "R8 event beats clear");
        #1 flag_ack = 1'b0;

        // R9 request gating
        cur_req = "R9";
        #1 gie = 1'b0; cyc(1);
        chk(irq_req, 1'b0, "R9 gie low");
        #1 gie = 1'b1; irq_en = 1'b0; cyc(1);
        chk(irq_req, 1'b0, "R9 enable low");
        chk(irq_flag, 1'b1, "R9 flag kept");
        clear_flag();

        // R10 no latch while disabled
        cur_req = "R10";
        #1 pin_raw = 1'b1; cyc(4);
        #1 pin_raw = 1'b0; cyc(4);
        chk(irq_flag, 1'b0, "R10 disabled activity");
        #1 irq_en = 1'b1; cyc(2);
        chk(irq_flag, 1'b0, "R10 no late set");

        // R11 spurious on sense change
        cur_req = "R11";
        set_mode(2'b10);
        #1 pin_raw = 1'b1; cyc(4);
        clear_flag();
        #1 sense = 2'b11; cyc(1);
        chk(irq_flag, 1'b1, "R11 spurious with enable set");
        cyc(1);
        chk(irq_req, 1'b1, "R11 spurious request");
        #1 irq_en = 1'b0; sense = 2'b10; cyc(2);
        #1 flag_w1c = 1'b1; cyc(1);
        #1 flag_w1c = 1'b0; sense = 2'b11; cyc(2);
        #1 irq_en = 1'b1; cyc(3);
        chk(irq_flag, 1'b0, "R11 no spurious with enable clear");

        // R12 chip-driven pad
        cur_req = "R12";
        #1 drv_en = 1'b1; drv_val = 1'b1; cyc(3);
        #1 drv_val = 1'b0; cyc(3);
        clear_flag();
        #1 pin_raw = 1'b1; cyc(3);
        chk(irq_flag, 1'b0, "R12 raw pin ignored");
        #1 drv_val = 1'b1; cyc(3);
        chk(irq_flag, 1'b1, "R12 driven rise sets");
        chk(irq_req, 1'b1, "R12 driven request");

        cyc(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule